// File: doc/BRIEF.md
# Shared GPIO Bank with Per-Pin Ownership

This block is a bank of general-purpose I/O pins shared by two processors. Each processor reaches the bank through its own register port, and both ports expose the same register set. That set holds pin output values, pin directions, the live input state, an interrupt match level, sticky interrupt flags, interrupt enables and a snapshot of the inputs taken once after reset. A per-pin owner register decides which port's output, direction and interrupt settings act on each pin. A global output-enable mask can switch any pin's driver off, whoever owns the pin.

The register ports use word indices. Reads are combinational from the current register state. A write lands on the rising clock edge where `sel` and `wr` are both high. Each pin input passes through a two-flop synchronizer before software or the interrupt logic sees it. Each port has its own interrupt line, and a pin contributes to a port's line only when that port owns the pin.

Top module: `gpio_dual_bank`

## Requirements
- R1: Word indices per port: 0 output, 1 direction, 2 input (read-only), 3 interrupt level, 4 interrupt flag, 5 interrupt enable, 6 input snapshot (read-only), 7 owner, 8 output-enable mask. Indices 9 to 15 read zero. Output, direction, level and enable read back what was last written through the same port, and all reset to zero.
- R2: A direction bit of 1 makes the pin drive and a 0 makes it an input. `pad_oe[i]` is the owning port's direction bit ANDed with the mask bit. `pad_out[i]` is the owning port's output bit.
- R3: Owner bit i at 1 hands pin i to the secondary port, and at 0 to the primary port. The owner register resets to zero.
- R4: The output-enable mask resets to all ones across the 24 implemented bits. Either port may write it, and the primary wins if both write in the same cycle. A cleared mask bit forces `pad_oe` low for that pin.
- R5: Mask bits 31 to 24 cannot be set and always read as zero.
- R6: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. If the set condition holds in the same cycle as a clear, the set wins.
- R7: In each port, flag bit i becomes 1 on the clock edge after the synchronized input bit i equals that port's level bit i. It then stays set until it is cleared.
- R8: `irq_pri` is high exactly when some pin owned by the primary has both its primary flag and its primary enable set. `irq_sec` follows the same rule for the secondary port.
- R9: A change at `pad_in` appears in the input register after two rising edges.
- R10: The input register reads the same live synchronized state from both ports, whatever the owner bits hold.
- R11: The snapshot register captures the synchronized inputs on the third rising edge after reset is released. That value is the pin state sampled at the first edge. The register then holds it.
- R12: Only the primary port can write the owner register. Owner writes from the secondary port have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| p_sel | input | 1 | Primary port access strobe |
| p_wr | input | 1 | Primary port write (1) or read (0) |
| p_addr | input | 4 | Primary port word index |
| p_wdata | input | 32 | Primary port write data |
| p_rdata | output | 32 | Primary port read data |
| s_sel | input | 1 | Secondary port access strobe |
| s_wr | input | 1 | Secondary port write (1) or read (0) |
| s_addr | input | 4 | Secondary port word index |
| s_wdata | input | 32 | Secondary port write data |
| s_rdata | output | 32 | Secondary port read data |
| pad_in | input | 24 | Raw pin inputs |
| pad_out | output | 24 | Pin output values |
| pad_oe | output | 24 | Pin output-driver enables |
| irq_pri | output | 1 | Interrupt toward the primary processor |
| irq_sec | output | 1 | Interrupt toward the secondary processor |

## Verification
A wrong owner or mask bit shows at once on `pad_out` and `pad_oe`. These outputs are combinational from registers, so the error is visible in the cycle after the offending write. A flag register with a bad set, clear or priority rule shows on the interrupt lines as soon as the matching enable is set. It also shows in a flag read one cycle after the event. A synchronizer of the wrong depth moves the input read and the flag set by one cycle, so the exact-cycle checks after each pin change catch it. A snapshot that is captured at the wrong time, or that does not hold, differs from the reset-time pin pattern once the pins change.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;
  // Word index of each register within a port's window.
  typedef enum logic [3:0] {
    RI_OUT  = 4'd0,
    RI_DIR  = 4'd1,
    RI_IN   = 4'd2,
    RI_LVL  = 4'd3,
    RI_FLAG = 4'd4,
    RI_IEN  = 4'd5,
    RI_MIR  = 4'd6,
    RI_OWN  = 4'd7,
    RI_MASK = 4'd8
  } reg_idx_e;

  localparam int unsigned PORT_COUNT = 2;
  localparam int unsigned PORT_PRI   = 0;
  localparam int unsigned PORT_SEC   = 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 24,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[i] <= '0;
          else        st[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[i] <= '0;
          else        st[i] <= st[i-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_dual_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int DW    = 32,
  parameter int RIW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic [RIW-1:0]   addr,
  input  logic [DW-1:0]    wdata,
  input  logic [NPINS-1:0] pin_sync,
  input  logic [NPINS-1:0] mirror,
  input  logic [NPINS-1:0] owner,
  input  logic [NPINS-1:0] mask,
  output logic [DW-1:0]    rdata,
  output logic [NPINS-1:0] out_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] lvl_q,
  output logic [NPINS-1:0] flag_q,
  output logic [NPINS-1:0] ien_q,
  output logic             own_wr,
  output logic             mask_wr
);
  localparam int PADW = DW - NPINS;

  // Bits whose synchronized input matches the programmed level.
  function automatic logic [NPINS-1:0] level_match(input logic [NPINS-1:0] pins,
                                                   input logic [NPINS-1:0] lvl);
    return ~(pins ^ lvl);
  endfunction

  // Sticky flag: clear on write-1, set wins over clear.
  function automatic logic [NPINS-1:0] flag_next(input logic [NPINS-1:0] cur,
                                                 input logic [NPINS-1:0] clr,
                                                 input logic [NPINS-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  logic             wr_en;
  logic [NPINS-1:0] wbits;
  logic [NPINS-1:0] hit;
  logic [NPINS-1:0] clr;
  logic             unused_wdata_hi;

  assign wr_en           = sel & wr;
  assign wbits           = wdata[NPINS-1:0];
  assign unused_wdata_hi = ^wdata[DW-1:NPINS];
  assign hit             = level_match(pin_sync, lvl_q);
  assign clr             = (wr_en && addr == RIW'(RI_FLAG)) ? wbits : '0;
  assign own_wr          = wr_en && addr == RIW'(RI_OWN);
  assign mask_wr         = wr_en && addr == RIW'(RI_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      lvl_q  <= '0;
      ien_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en && addr == RIW'(RI_OUT)) out_q <= wbits;
      if (wr_en && addr == RIW'(RI_DIR)) dir_q <= wbits;
      if (wr_en && addr == RIW'(RI_LVL)) lvl_q <= wbits;
      if (wr_en && addr == RIW'(RI_IEN)) ien_q <= wbits;
      flag_q <= flag_next(flag_q, clr, hit);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RIW'(RI_OUT):  rdata = {{PADW{1'b0}}, out_q};
      RIW'(RI_DIR):  rdata = {{PADW{1'b0}}, dir_q};
      RIW'(RI_IN):   rdata = {{PADW{1'b0}}, pin_sync};
      RIW'(RI_LVL):  rdata = {{PADW{1'b0}}, lvl_q};
      RIW'(RI_FLAG): rdata = {{PADW{1'b0}}, flag_q};
      RIW'(RI_IEN):  rdata = {{PADW{1'b0}}, ien_q};
      RIW'(RI_MIR):  rdata = {{PADW{1'b0}}, mirror};
      RIW'(RI_OWN):  rdata = {{PADW{1'b0}}, owner};
      RIW'(RI_MASK): rdata = {{PADW{1'b0}}, mask};
      default:       rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_shared_regs.sv
module gpio_shared_regs #(
  parameter int NPINS       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pri_own_wr,
  input  logic             pri_mask_wr,
  input  logic [NPINS-1:0] pri_wbits,
  input  logic             sec_mask_wr,
  input  logic [NPINS-1:0] sec_wbits,
  input  logic [NPINS-1:0] pin_sync,
  output logic [NPINS-1:0] owner_q,
  output logic [NPINS-1:0] mask_q,
  output logic [NPINS-1:0] mirror_q,
  output logic             cap_done
);
  localparam int WARM_W = $clog2(SYNC_STAGES + 1);
  localparam logic [WARM_W-1:0] WARM_END = WARM_W'(SYNC_STAGES);

  logic [WARM_W-1:0] warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
      mask_q  <= '1;
    end else begin
      if (pri_own_wr) owner_q <= pri_wbits;
      if (pri_mask_wr)      mask_q <= pri_wbits;
      else if (sec_mask_wr) mask_q <= sec_wbits;
    end
  end

  // Snapshot once the synchronizer has filled with post-reset samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm     <= '0;
      cap_done <= 1'b0;
      mirror_q <= '0;
    end else if (!cap_done) begin
      if (warm == WARM_END) begin
        mirror_q <= pin_sync;
        cap_done <= 1'b1;
      end else begin
        warm <= warm + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_pin_arb.sv
module gpio_pin_arb #(
  parameter int NPINS = 24
) (
  input  logic [NPINS-1:0] owner,
  input  logic [NPINS-1:0] mask,
  input  logic [NPINS-1:0] out_p,
  input  logic [NPINS-1:0] out_s,
  input  logic [NPINS-1:0] dir_p,
  input  logic [NPINS-1:0] dir_s,
  input  logic [NPINS-1:0] flag_p,
  input  logic [NPINS-1:0] flag_s,
  input  logic [NPINS-1:0] ien_p,
  input  logic [NPINS-1:0] ien_s,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pend_p,
  output logic [NPINS-1:0] pend_s,
  output logic             irq_p,
  output logic             irq_s
);
  // Per-bit select: 1 takes the secondary value.
  function automatic logic [NPINS-1:0] pick(input logic [NPINS-1:0] s,
                                            input logic [NPINS-1:0] a,
                                            input logic [NPINS-1:0] b);
    return (a & ~s) | (b & s);
  endfunction

  assign pad_out = pick(owner, out_p, out_s);
  assign pad_oe  = pick(owner, dir_p, dir_s) & mask;
  assign pend_p  = flag_p & ien_p & ~owner;
  assign pend_s  = flag_s & ien_s & owner;
  assign irq_p   = |pend_p;
  assign irq_s   = |pend_s;
endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
  import gpio_dual_pkg::*;
#(
  parameter int NPINS       = 24,
  parameter int DW          = 32,
  parameter int RIW         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             p_sel,
  input  logic             p_wr,
  input  logic [RIW-1:0]   p_addr,
  input  logic [DW-1:0]    p_wdata,
  output logic [DW-1:0]    p_rdata,
  input  logic             s_sel,
  input  logic             s_wr,
  input  logic [RIW-1:0]   s_addr,
  input  logic [DW-1:0]    s_wdata,
  output logic [DW-1:0]    s_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq_pri,
  output logic             irq_sec
);
  logic [PORT_COUNT-1:0]            b_sel, b_wr, own_wr, mask_wr;
  logic [PORT_COUNT-1:0][RIW-1:0]   b_addr;
  logic [PORT_COUNT-1:0][DW-1:0]    b_wdata, b_rdata;
  logic [PORT_COUNT-1:0][NPINS-1:0] out_q, dir_q, lvl_q, flag_q, ien_q;
  logic [NPINS-1:0] pin_sync, owner_q, mask_q, mirror_q, pend_p, pend_s;
  logic             cap_done;
  logic             unused_sec_own_wr;

  assign b_sel[PORT_PRI]   = p_sel;
  assign b_wr[PORT_PRI]    = p_wr;
  assign b_addr[PORT_PRI]  = p_addr;
  assign b_wdata[PORT_PRI] = p_wdata;
  assign b_sel[PORT_SEC]   = s_sel;
  assign b_wr[PORT_SEC]    = s_wr;
  assign b_addr[PORT_SEC]  = s_addr;
  assign b_wdata[PORT_SEC] = s_wdata;
  assign p_rdata           = b_rdata[PORT_PRI];
  assign s_rdata           = b_rdata[PORT_SEC];
  // The secondary port has no path into the owner register.
  assign unused_sec_own_wr = own_wr[PORT_SEC];

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  generate
    for (genvar b = 0; b < PORT_COUNT; b++) begin : g_bank
      gpio_bank_regs #(.NPINS(NPINS), .DW(DW), .RIW(RIW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .sel(b_sel[b]), .wr(b_wr[b]), .addr(b_addr[b]), .wdata(b_wdata[b]),
        .pin_sync(pin_sync), .mirror(mirror_q), .owner(owner_q), .mask(mask_q),
        .rdata(b_rdata[b]),
        .out_q(out_q[b]), .dir_q(dir_q[b]), .lvl_q(lvl_q[b]),
        .flag_q(flag_q[b]), .ien_q(ien_q[b]),
        .own_wr(own_wr[b]), .mask_wr(mask_wr[b])
      );
    end
  endgenerate

  gpio_shared_regs #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_shared (
    .clk(clk), .rst_n(rst_n),
    .pri_own_wr(own_wr[PORT_PRI]), .pri_mask_wr(mask_wr[PORT_PRI]),
    .pri_wbits(p_wdata[NPINS-1:0]),
    .sec_mask_wr(mask_wr[PORT_SEC]), .sec_wbits(s_wdata[NPINS-1:0]),
    .pin_sync(pin_sync),
    .owner_q(owner_q), .mask_q(mask_q), .mirror_q(mirror_q), .cap_done(cap_done)
  );

  gpio_pin_arb #(.NPINS(NPINS)) u_arb (
    .owner(owner_q), .mask(mask_q),
    .out_p(out_q[PORT_PRI]),   .out_s(out_q[PORT_SEC]),
    .dir_p(dir_q[PORT_PRI]),   .dir_s(dir_q[PORT_SEC]),
    .flag_p(flag_q[PORT_PRI]), .flag_s(flag_q[PORT_SEC]),
    .ien_p(ien_q[PORT_PRI]),   .ien_s(ien_q[PORT_SEC]),
    .pad_out(pad_out), .pad_oe(pad_oe),
    .pend_p(pend_p), .pend_s(pend_s),
    .irq_p(irq_pri), .irq_s(irq_sec)
  );
endmodule

// File: rtl/gpio_dual_chk.sv
module gpio_dual_chk
  import gpio_dual_pkg::*;
#(
  parameter int NPINS       = 24,
  parameter int DW          = 32,
  parameter int RIW         = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             p_sel,
  input logic             p_wr,
  input logic [RIW-1:0]   p_addr,
  input logic [DW-1:0]    p_rdata,
  input logic             s_sel,
  input logic             s_wr,
  input logic [RIW-1:0]   s_addr,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pad_oe,
  input logic             irq_pri,
  input logic             irq_sec,
  input logic [NPINS-1:0] pin_sync,
  input logic [NPINS-1:0] owner_q,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] mirror_q,
  input logic             cap_done,
  input logic [NPINS-1:0] lvl_p,
  input logic [NPINS-1:0] flag_p,
  input logic [NPINS-1:0] ien_p,
  input logic [NPINS-1:0] ien_s
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_OE_WITHIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~mask_q) == '0); // R4

  AST_MASK_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (p_sel && !p_wr && p_addr == RIW'(RI_MASK)) |-> p_rdata[DW-1:NPINS] == '0); // R5

  AST_SEC_OWNER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (s_sel && s_wr && s_addr == RIW'(RI_OWN) && !(p_sel && p_wr && p_addr == RIW'(RI_OWN)))
    |=> $stable(owner_q)); // R12

  AST_MIRROR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |=> (cap_done && $stable(mirror_q))); // R11

  AST_FLAG_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0) |-> ((~($past(pin_sync) ^ $past(lvl_p)) & ~flag_p) == '0)); // R7

  AST_IRQ_PRI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pri |-> ((ien_p & ~owner_q) != '0)); // R8

  AST_IRQ_SEC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sec |-> ((ien_s & owner_q) != '0)); // R8

  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> pin_sync == $past(pad_in, 2)); // R9
    end
  endgenerate
endmodule

bind gpio_dual_bank gpio_dual_chk #(
  .NPINS(NPINS), .DW(DW), .RIW(RIW), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .p_sel(p_sel), .p_wr(p_wr), .p_addr(p_addr), .p_rdata(p_rdata),
  .s_sel(s_sel), .s_wr(s_wr), .s_addr(s_addr),
  .pad_in(pad_in), .pad_oe(pad_oe), .irq_pri(irq_pri), .irq_sec(irq_sec),
  .pin_sync(pin_sync), .owner_q(owner_q), .mask_q(mask_q), .mirror_q(mirror_q),
  .cap_done(cap_done),
  .lvl_p(lvl_q[0]), .flag_p(flag_q[0]), .ien_p(ien_q[0]), .ien_s(ien_q[1])
);

// File: tb/sim_gpio_dual_bank.sv
`timescale 1ns/1ps
module sim_gpio_dual_bank;
  localparam logic [31:0] PM = 32'h00FF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        p_sel = 0, p_wr = 0, s_sel = 0, s_wr = 0;
  logic [3:0]  p_addr = '0, s_addr = '0;
  logic [31:0] p_wdata = '0, s_wdata = '0, p_rdata, s_rdata;
  logic [23:0] pad_in = 24'h5A0F3C, pad_out, pad_oe;
  logic        irq_pri, irq_sec;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_dual_bank u0 (
    .clk(clk), .rst_n(rst_n),
    .p_sel(p_sel), .p_wr(p_wr), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
    .s_sel(s_sel), .s_wr(s_wr), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_pri(irq_pri), .irq_sec(irq_sec)
  );

  // Behavioural reference state, 32-bit words per port.
  logic [31:0] m_out[2], m_dir[2], m_lvl[2], m_flag[2], m_ien[2];
  logic [31:0] m_own, m_mask, m_s1, m_s2, m_mir;
  int          m_warm;
  bit          m_cap;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        m_out[b] <= 0; m_dir[b] <= 0; m_lvl[b] <= 0; m_flag[b] <= 0; m_ien[b] <= 0;
      end
      m_own <= 0; m_mask <= PM; m_s1 <= 0; m_s2 <= 0; m_mir <= 0; m_warm <= 0; m_cap <= 0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        bit          w;
        int          a;
        logic [31:0] d, clr;
        w   = (b == 0) ? (p_sel && p_wr) : (s_sel && s_wr);
        a   = (b == 0) ? int'(p_addr) : int'(s_addr);
        d   = ((b == 0) ? p_wdata : s_wdata) & PM;
        clr = (w && a == 4) ? d : 0;
        if (w && a == 0) m_out[b] <= d;
        if (w && a == 1) m_dir[b] <= d;
        if (w && a == 3) m_lvl[b] <= d;
        if (w && a == 5) m_ien[b] <= d;
        m_flag[b] <= ((m_flag[b] & ~clr) | ~(m_s2 ^ m_lvl[b])) & PM;
      end
      if (p_sel && p_wr && p_addr == 4'd7) m_own <= p_wdata & PM;
      if (p_sel && p_wr && p_addr == 4'd8) m_mask <= p_wdata & PM;
      else if (s_sel && s_wr && s_addr == 4'd8) m_mask <= s_wdata & PM;
      m_s1 <= {8'h0, pad_in};
      m_s2 <= m_s1;
      if (!m_cap) begin
        if (m_warm == 2) begin m_mir <= m_s2; m_cap <= 1; end
        else m_warm <= m_warm + 1;
      end
    end
  end

  function automatic logic [31:0] m_read(int b, int idx);
    case (idx)
      0: return m_out[b];
      1: return m_dir[b];
      2: return m_s2;
      3: return m_lvl[b];
      4: return m_flag[b];
      5: return m_ien[b];
      6: return m_mir;
      7: return m_own;
      8: return m_mask;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // Every cycle: pads and interrupt lines against the reference (R2 R3 R4 R8).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R3 pad_out", {8'h0, pad_out}, (m_out[0] & ~m_own) | (m_out[1] & m_own));
      chk("R2 R4 pad_oe", {8'h0, pad_oe}, ((m_dir[0] & ~m_own) | (m_dir[1] & m_own)) & m_mask);
      chk("R8 irq_pri", {31'h0, irq_pri}, {31'h0, |(m_flag[0] & m_ien[0] & ~m_own)});
      chk("R8 irq_sec", {31'h0, irq_sec}, {31'h0, |(m_flag[1] & m_ien[1] & m_own)});
    end
  end

  task automatic wr(bit sec, logic [3:0] idx, logic [31:0] d);
    @(negedge clk);
    if (sec) begin s_sel = 1; s_wr = 1; s_addr = idx; s_wdata = d; end
    else     begin p_sel = 1; p_wr = 1; p_addr = idx; p_wdata = d; end
    @(negedge clk);
    p_sel = 0; p_wr = 0; s_sel = 0; s_wr = 0;
  endtask

  task automatic rd(bit sec, logic [3:0] idx, logic [31:0] exp, string tag);
    logic [31:0] got;
    @(negedge clk);
    if (sec) begin s_sel = 1; s_addr = idx; end
    else     begin p_sel = 1; p_addr = idx; end
    #1;
    got = sec ? s_rdata : p_rdata;
    chk(tag, got, exp);
    chk({tag, " model"}, got, m_read(sec ? 1 : 0, int'(idx)));
    p_sel = 0; s_sel = 0;
  endtask

  task automatic pins(logic [23:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got hang exp completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    chk("R2 reset pad_oe", {8'h0, pad_oe}, 0);
    chk("R1 reset pad_out", {8'h0, pad_out}, 0);
    chk("R8 reset irq", {30'h0, irq_pri, irq_sec}, 0);
    rd(0, 4'd8, 32'h00FF_FFFF, "R4 mask reset");
    repeat (3) @(negedge clk);
    rd(0, 4'd6, 32'h005A_0F3C, "R11 snapshot pri");
    rd(1, 4'd6, 32'h005A_0F3C, "R11 snapshot sec");
    rd(1, 4'd2, 32'h005A_0F3C, "R10 input sec");

    wr(0, 4'd0, 32'hFFA5_A5A5);
    wr(0, 4'd1, 32'h00FF_FFFF);
    chk("R2 drive out", {8'h0, pad_out}, 32'h00A5_A5A5);
    chk("R2 drive oe", {8'h0, pad_oe}, 32'h00FF_FFFF);

    wr(1, 4'd0, 32'h0012_3456);
    wr(1, 4'd1, 32'h0000_000F);
    wr(1, 4'd7, 32'h0000_00FF);
    rd(0, 4'd7, 32'h0, "R12 sec owner write ignored");
    chk("R12 pads unchanged", {8'h0, pad_out}, 32'h00A5_A5A5);

    wr(0, 4'd7, 32'h0000_00F0);
    chk("R3 owner out", {8'h0, pad_out}, 32'h00A5_A555);
    chk("R3 owner oe", {8'h0, pad_oe}, 32'h00FF_FF0F);

    wr(1, 4'd8, 32'hFFFF_00FF);
    rd(0, 4'd8, 32'h00FF_00FF, "R5 mask top zero");
    chk("R4 mask gates oe", {8'h0, pad_oe}, 32'h00FF_000F);

    rd(0, 4'd0, 32'h00A5_A5A5, "R1 out readback");
    rd(1, 4'd1, 32'h0000_000F, "R1 dir readback");
    rd(0, 4'd3, 32'h0, "R1 level reset");
    rd(1, 4'd5, 32'h0, "R1 enable reset");
    rd(0, 4'd12, 32'h0, "R1 unmapped index");

    pins(24'h000008);
    rd(0, 4'd2, 32'h005A_0F3C, "R9 input after one edge");
    rd(1, 4'd2, 32'h0000_0008, "R9 R10 input after two edges");
    rd(0, 4'd6, 32'h005A_0F3C, "R11 snapshot held");

    wr(0, 4'd3, 32'h00FF_FFFF);
    wr(0, 4'd4, 32'h00FF_FFFF);
    rd(0, 4'd4, 32'h0000_0008, "R6 set wins over clear");
    wr(1, 4'd4, 32'h00FF_FFFF);
    pins(24'h000000);
    repeat (3) @(negedge clk);
    rd(1, 4'd4, 32'h00FF_FFFF, "R7 low-level match");
    rd(0, 4'd4, 32'h0000_0008, "R7 flag sticky");
    wr(0, 4'd4, 32'h0);
    rd(0, 4'd4, 32'h0000_0008, "R6 write zero keeps");
    wr(0, 4'd4, 32'h0000_0008);
    rd(0, 4'd4, 32'h0, "R6 write one clears");

    wr(0, 4'd5, 32'h0000_0008);
    chk("R8 no flag no irq", {31'h0, irq_pri}, 0);
    pins(24'h000008);
    repeat (3) @(negedge clk);
    chk("R8 irq_pri raised", {31'h0, irq_pri}, 1);
    wr(0, 4'd7, 32'h0000_00F8);
    chk("R8 irq_pri drops on handover", {31'h0, irq_pri}, 0);
    wr(1, 4'd5, 32'h0000_0008);
    chk("R8 irq_sec raised", {31'h0, irq_sec}, 1);
    wr(0, 4'd8, 32'h0);
    chk("R4 mask clear all", {8'h0, pad_oe}, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule